// File: doc/BRIEF.md
# Bus Boundary-Scan Data Register

This block is the boundary-scan data register for a device whose external bus has a 32-bit address, a 32-bit bidirectional data path, three strobes (output enable, write enable, chip select) and a reset input. It has 202 cells. A shift stage captures the values at the pins and serialises them through a test data path. An update latch holds a pattern that can be driven onto the pins. A TAP controller outside the block supplies the capture, shift and update strobes and a one-bit mode select. That select chooses external test (the pins come from the latch) or sample (the pins come from the core, and the register only observes them).

The cell layout is fixed, and the cells of one kind are grouped rather than interleaved per pin. The address, data and strobe output cells come first. Next come the reset input and a block of spare cells, then the address enables and the data input and enable cells. A final pair region holds, for each strobe, a spare cell followed by that strobe's enable cell.

Top module: `bscan_bus_reg`

## Requirements
- R1: The register is 202 cells long. A bit shifted in on `tdi_i` appears on `tdo_o` after 201 further shifts, and no sooner.
- R2: Each shift moves every cell one place toward cell 0. `tdi_i` enters cell 201, and `tdo_o` always shows cell 0.
- R3: On capture, output cells load the core's values and enable cells load the core's enables. Address bit n goes to cell n, data bit n to cell 32+n, and strobe k to cell 64+k (k=0 output enable, 1 write enable, 2 chip select). The address enable n goes to cell 100+n, the data enable n to cell 164+n, and the strobe enable k to cell 197+2k.
- R4: On capture, the reset pin loads cell 67 and data pin n loads cell 132+n.
- R5: Cells 68 to 99, 196, 198 and 200 are spare cells. They capture 0 and only shift.
- R6: The update latch changes only when the update strobe is present. In external test mode, capture and shift leave the pins and enables unchanged.
- R7: In external test mode, the pins take the latch: the address from cells 0 to 31, the data from cells 32 to 63, and the strobes from cells 64 to 66. The core's values are then ignored.
- R8: In external test mode, each enable output equals its enable cell (same indices as R3). A 1 drives the pin and a 0 leaves it floating.
- R9: Outside external test mode, every pin output and enable equals the core's value in the same cycle, whatever the register does.
- R10: Reset clears the shift stage and the latch. `tdo_o` is then 0, and external test mode with no update gives all enables 0.
- R11: When capture and shift are both present, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| extest_i | input | 1 | 1 selects external test, 0 selects sample |
| tdi_i | input | 1 | Serial data in, into cell 201 |
| tdo_o | output | 1 | Serial data out, cell 0 |
| core_addr_i | input | 32 | Core address |
| core_addr_en_i | input | 32 | Core address drive enables |
| core_data_i | input | 32 | Core write data |
| core_data_en_i | input | 32 | Core data drive enables |
| core_strb_i | input | 3 | Core strobes {chip select, write enable, output enable} |
| core_strb_en_i | input | 3 | Core strobe drive enables |
| pin_data_i | input | 32 | Data pin levels |
| pin_rst_i | input | 1 | Reset pin level |
| pin_addr_o | output | 32 | Address pin value |
| pin_addr_en_o | output | 32 | Address pin drive enables |
| pin_data_o | output | 32 | Data pin value |
| pin_data_en_o | output | 32 | Data pin drive enables |
| pin_strb_o | output | 3 | Strobe pin values |
| pin_strb_en_o | output | 3 | Strobe pin drive enables |

## Verification
Results fall due at different times. In sample mode the pins follow the core in the same cycle, with no register in the path. `tdo_o` reflects a capture or a shift one clock edge after the strobe. In external test mode the pins take a new pattern one edge after the update strobe. The bench changes inputs on the falling edge and advances its behavioural model for the rising edge that follows. It then compares every output at the next falling edge, so each comparison lands one edge after its stimulus. After a capture, the bench shifts all 202 cells out one per cycle and checks each bit against the cell map.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

  // Cell sections in chain order, starting at cell 0
  typedef enum int {
    SEC_A_OUT, SEC_D_OUT, SEC_S_OUT, SEC_RST_IN, SEC_SPARE,
    SEC_A_CTL, SEC_D_IN, SEC_D_CTL, SEC_S_PAIR, SEC_END
  } sec_e;

  function automatic int sec_size(sec_e s, int aw, int dw, int sn);
    case (s)
      SEC_A_OUT:  return aw;
      SEC_D_OUT:  return dw;
      SEC_S_OUT:  return sn;
      SEC_RST_IN: return 1;
      SEC_SPARE:  return aw;
      SEC_A_CTL:  return aw;
      SEC_D_IN:   return dw;
      SEC_D_CTL:  return dw;
      SEC_S_PAIR: return 2 * sn;
      default:    return 0;
    endcase
  endfunction

  function automatic int sec_base(sec_e s, int aw, int dw, int sn);
    int b;
    b = 0;
    for (int k = 0; k < int'(s); k++) b += sec_size(sec_e'(k), aw, dw, sn);
    return b;
  endfunction

endpackage

// File: rtl/bsr_cell_map.sv
`timescale 1ns/1ps
module bsr_cell_map #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SN    = 3,
  parameter int LEN   = 202,
  parameter int DRV_W = 2 * (AW + DW + SN)
) (
  input  logic [AW-1:0]    core_addr_i,
  input  logic [AW-1:0]    core_addr_en_i,
  input  logic [DW-1:0]    core_data_i,
  input  logic [DW-1:0]    core_data_en_i,
  input  logic [SN-1:0]    core_strb_i,
  input  logic [SN-1:0]    core_strb_en_i,
  input  logic [DW-1:0]    pin_data_i,
  input  logic             pin_rst_i,
  input  logic [LEN-1:0]   cell_i,
  output logic [LEN-1:0]   cap_o,
  output logic [DRV_W-1:0] drv_o
);
  import bsr_pkg::*;

  localparam int A_OUT  = sec_base(SEC_A_OUT,  AW, DW, SN);
  localparam int D_OUT  = sec_base(SEC_D_OUT,  AW, DW, SN);
  localparam int S_OUT  = sec_base(SEC_S_OUT,  AW, DW, SN);
  localparam int RST_IN = sec_base(SEC_RST_IN, AW, DW, SN);
  localparam int SPARE  = sec_base(SEC_SPARE,  AW, DW, SN);
  localparam int A_CTL  = sec_base(SEC_A_CTL,  AW, DW, SN);
  localparam int D_IN   = sec_base(SEC_D_IN,   AW, DW, SN);
  localparam int D_CTL  = sec_base(SEC_D_CTL,  AW, DW, SN);
  localparam int S_PAIR = sec_base(SEC_S_PAIR, AW, DW, SN);

  // Capture source per cell
  for (genvar i = 0; i < LEN; i++) begin : g_cap
    if (i < D_OUT) begin : g_aout
      assign cap_o[i] = core_addr_i[i-A_OUT];
    end else if (i < S_OUT) begin : g_dout
      assign cap_o[i] = core_data_i[i-D_OUT];
    end else if (i < RST_IN) begin : g_sout
      assign cap_o[i] = core_strb_i[i-S_OUT];
    end else if (i == RST_IN) begin : g_rst
      assign cap_o[i] = pin_rst_i;
    end else if (i < A_CTL) begin : g_spare
      assign cap_o[i] = 1'b0;
    end else if (i < D_IN) begin : g_actl
      assign cap_o[i] = core_addr_en_i[i-A_CTL];
    end else if (i < D_CTL) begin : g_din
      assign cap_o[i] = pin_data_i[i-D_IN];
    end else if (i < S_PAIR) begin : g_dctl
      assign cap_o[i] = core_data_en_i[i-D_CTL];
    end else if (((i - S_PAIR) % 2) == 0) begin : g_spair
      assign cap_o[i] = 1'b0;
    end else begin : g_sctl
      assign cap_o[i] = core_strb_en_i[(i-S_PAIR)/2];
    end
  end

  // Drive fields taken from the chain
  logic [SN-1:0] strb_en_cells;
  logic [SN-1:0] unused_pair_spare;
  for (genvar k = 0; k < SN; k++) begin : g_sfld
    assign strb_en_cells[k]     = cell_i[S_PAIR + 2*k + 1];
    assign unused_pair_spare[k] = cell_i[S_PAIR + 2*k];
  end

  assign drv_o = {strb_en_cells,
                  cell_i[S_OUT +: SN],
                  cell_i[D_CTL +: DW],
                  cell_i[D_OUT +: DW],
                  cell_i[A_CTL +: AW],
                  cell_i[A_OUT +: AW]};

  logic unused_cells;
  assign unused_cells = ^{cell_i[RST_IN], cell_i[SPARE +: AW], cell_i[D_IN +: DW],
                          unused_pair_spare};

endmodule

// File: rtl/bsr_shift_stage.sv
`timescale 1ns/1ps
module bsr_shift_stage #(
  parameter int LEN = 202
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           capture_i,
  input  logic           shift_i,
  input  logic           tdi_i,
  input  logic [LEN-1:0] cap_i,
  output logic [LEN-1:0] cell_o,
  output logic           tdo_o
);
  logic [LEN-1:0] cell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cell_q <= '0;
    else if (capture_i) cell_q <= cap_i;
    else if (shift_i)   cell_q <= {tdi_i, cell_q[LEN-1:1]};
  end

  assign cell_o = cell_q;
  assign tdo_o  = cell_q[0];
endmodule

// File: rtl/bsr_update_latch.sv
`timescale 1ns/1ps
module bsr_update_latch #(
  parameter int W = 134
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         update_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (update_i) q_o <= d_i;
  end
endmodule

// File: rtl/bsr_pin_mux.sv
`timescale 1ns/1ps
module bsr_pin_mux #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SN    = 3,
  parameter int DRV_W = 2 * (AW + DW + SN)
) (
  input  logic             extest_i,
  input  logic [DRV_W-1:0] scan_drv_i,
  input  logic [AW-1:0]    core_addr_i,
  input  logic [AW-1:0]    core_addr_en_i,
  input  logic [DW-1:0]    core_data_i,
  input  logic [DW-1:0]    core_data_en_i,
  input  logic [SN-1:0]    core_strb_i,
  input  logic [SN-1:0]    core_strb_en_i,
  output logic [AW-1:0]    pin_addr_o,
  output logic [AW-1:0]    pin_addr_en_o,
  output logic [DW-1:0]    pin_data_o,
  output logic [DW-1:0]    pin_data_en_o,
  output logic [SN-1:0]    pin_strb_o,
  output logic [SN-1:0]    pin_strb_en_o
);
  logic [DRV_W-1:0] core_drv;
  logic [DRV_W-1:0] sel_drv;

  assign core_drv = {core_strb_en_i, core_strb_i, core_data_en_i, core_data_i,
                     core_addr_en_i, core_addr_i};
  assign sel_drv  = extest_i ? scan_drv_i : core_drv;

  assign {pin_strb_en_o, pin_strb_o, pin_data_en_o, pin_data_o,
          pin_addr_en_o, pin_addr_o} = sel_drv;
endmodule

// File: rtl/bscan_bus_reg.sv
`timescale 1ns/1ps
module bscan_bus_reg #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          shift_i,
  input  logic          update_i,
  input  logic          extest_i,
  input  logic          tdi_i,
  output logic          tdo_o,
  input  logic [AW-1:0] core_addr_i,
  input  logic [AW-1:0] core_addr_en_i,
  input  logic [DW-1:0] core_data_i,
  input  logic [DW-1:0] core_data_en_i,
  input  logic [SN-1:0] core_strb_i,
  input  logic [SN-1:0] core_strb_en_i,
  input  logic [DW-1:0] pin_data_i,
  input  logic          pin_rst_i,
  output logic [AW-1:0] pin_addr_o,
  output logic [AW-1:0] pin_addr_en_o,
  output logic [DW-1:0] pin_data_o,
  output logic [DW-1:0] pin_data_en_o,
  output logic [SN-1:0] pin_strb_o,
  output logic [SN-1:0] pin_strb_en_o
);
  import bsr_pkg::*;

  localparam int LEN   = sec_base(SEC_END, AW, DW, SN);
  localparam int DRV_W = 2 * (AW + DW + SN);

  logic [LEN-1:0]   cap_v;
  logic [LEN-1:0]   cell_q;
  logic [DRV_W-1:0] drv_next;
  logic [DRV_W-1:0] drv_q;

  bsr_cell_map #(.AW(AW), .DW(DW), .SN(SN), .LEN(LEN), .DRV_W(DRV_W)) u_map (
    .core_addr_i    (core_addr_i),
    .core_addr_en_i (core_addr_en_i),
    .core_data_i    (core_data_i),
    .core_data_en_i (core_data_en_i),
    .core_strb_i    (core_strb_i),
    .core_strb_en_i (core_strb_en_i),
    .pin_data_i     (pin_data_i),
    .pin_rst_i      (pin_rst_i),
    .cell_i         (cell_q),
    .cap_o          (cap_v),
    .drv_o          (drv_next)
  );

  bsr_shift_stage #(.LEN(LEN)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .tdi_i     (tdi_i),
    .cap_i     (cap_v),
    .cell_o    (cell_q),
    .tdo_o     (tdo_o)
  );

  bsr_update_latch #(.W(DRV_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .d_i      (drv_next),
    .q_o      (drv_q)
  );

  bsr_pin_mux #(.AW(AW), .DW(DW), .SN(SN), .DRV_W(DRV_W)) u_mux (
    .extest_i       (extest_i),
    .scan_drv_i     (drv_q),
    .core_addr_i    (core_addr_i),
    .core_addr_en_i (core_addr_en_i),
    .core_data_i    (core_data_i),
    .core_data_en_i (core_data_en_i),
    .core_strb_i    (core_strb_i),
    .core_strb_en_i (core_strb_en_i),
    .pin_addr_o     (pin_addr_o),
    .pin_addr_en_o  (pin_addr_en_o),
    .pin_data_o     (pin_data_o),
    .pin_data_en_o  (pin_data_en_o),
    .pin_strb_o     (pin_strb_o),
    .pin_strb_en_o  (pin_strb_en_o)
  );
endmodule

// File: rtl/bscan_bus_reg_chk.sv
`timescale 1ns/1ps
module bscan_bus_reg_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int LEN = 202
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           capture_i,
  input logic           shift_i,
  input logic           update_i,
  input logic           extest_i,
  input logic           tdo_o,
  input logic [AW-1:0]  core_addr_i,
  input logic [AW-1:0]  core_addr_en_i,
  input logic [DW-1:0]  core_data_i,
  input logic [AW-1:0]  pin_addr_o,
  input logic [AW-1:0]  pin_addr_en_o,
  input logic [DW-1:0]  pin_data_o,
  input logic [LEN-1:0] cell_q
);
  assert_sample_passthru_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !extest_i |-> (pin_addr_o == core_addr_i) && (pin_addr_en_o == core_addr_en_i) &&
                  (pin_data_o == core_data_i));

  assert_pins_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (extest_i && $past(extest_i) && !$past(update_i)) |->
      $stable(pin_addr_o) && $stable(pin_addr_en_o) && $stable(pin_data_o));

  assert_capture_cell0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> tdo_o == $past(core_addr_i[0]));

  assert_shift_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> tdo_o == $past(cell_q[1]));

  assert_update_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(update_i) && extest_i) |->
      (pin_addr_o == $past(cell_q[AW-1:0])) && (pin_data_o == $past(cell_q[AW +: DW])));
endmodule

bind bscan_bus_reg bscan_bus_reg_chk #(.AW(AW), .DW(DW), .LEN(LEN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .capture_i      (capture_i),
  .shift_i        (shift_i),
  .update_i       (update_i),
  .extest_i       (extest_i),
  .tdo_o          (tdo_o),
  .core_addr_i    (core_addr_i),
  .core_addr_en_i (core_addr_en_i),
  .core_data_i    (core_data_i),
  .pin_addr_o     (pin_addr_o),
  .pin_addr_en_o  (pin_addr_en_o),
  .pin_data_o     (pin_data_o),
  .cell_q         (cell_q)
);

// File: tb/bscan_bus_reg_test.sv
`timescale 1ns/1ps
module bscan_bus_reg_test;
  localparam int LEN = 202;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic capture_i = 0, shift_i = 0, update_i = 0, extest_i = 0, tdi_i = 0;
  logic [31:0] core_addr_i = '0, core_addr_en_i = '0, core_data_i = '0, core_data_en_i = '0;
  logic [31:0] pin_data_i = '0;
  logic [2:0]  core_strb_i = '0, core_strb_en_i = '0;
  logic        pin_rst_i = 1'b0;
  logic        tdo_o;
  logic [31:0] pin_addr_o, pin_addr_en_o, pin_data_o, pin_data_en_o;
  logic [2:0]  pin_strb_o, pin_strb_en_o;

  bscan_bus_reg uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture_i), .shift_i(shift_i),
    .update_i(update_i), .extest_i(extest_i), .tdi_i(tdi_i), .tdo_o(tdo_o),
    .core_addr_i(core_addr_i), .core_addr_en_i(core_addr_en_i),
    .core_data_i(core_data_i), .core_data_en_i(core_data_en_i),
    .core_strb_i(core_strb_i), .core_strb_en_i(core_strb_en_i),
    .pin_data_i(pin_data_i), .pin_rst_i(pin_rst_i),
    .pin_addr_o(pin_addr_o), .pin_addr_en_o(pin_addr_en_o),
    .pin_data_o(pin_data_o), .pin_data_en_o(pin_data_en_o),
    .pin_strb_o(pin_strb_o), .pin_strb_en_o(pin_strb_en_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [LEN-1:0] m_sr = '0;
  logic [LEN-1:0] m_lat = '0;

  // Capture image from the cell map stated in R3, R4, R5
  function automatic logic [LEN-1:0] cap_img();
    logic [LEN-1:0] v;
    v = '0;
    for (int n = 0; n < 32; n++) begin
      v[n]       = core_addr_i[n];
      v[32 + n]  = core_data_i[n];
      v[100 + n] = core_addr_en_i[n];
      v[132 + n] = pin_data_i[n];
      v[164 + n] = core_data_en_i[n];
    end
    for (int k = 0; k < 3; k++) begin
      v[64 + k]    = core_strb_i[k];
      v[197 + 2*k] = core_strb_en_i[k];
    end
    v[67] = pin_rst_i;
    return v;
  endfunction

  function automatic string cell_tag(int j);
    if (j == 67 || (j >= 132 && j < 164)) return "R4";
    if ((j >= 68 && j < 100) || j == 196 || j == 198 || j == 200) return "R5";
    return "R3";
  endfunction

  task automatic check(string tag);
    logic [31:0] ea, eae, ed, ede;
    logic [2:0]  es, ese;
    logic bad;
    if (extest_i) begin
      for (int n = 0; n < 32; n++) begin
        ea[n] = m_lat[n]; ed[n] = m_lat[32 + n];
        eae[n] = m_lat[100 + n]; ede[n] = m_lat[164 + n];
      end
      for (int k = 0; k < 3; k++) begin
        es[k] = m_lat[64 + k]; ese[k] = m_lat[197 + 2*k];
      end
    end else begin
      ea = core_addr_i; eae = core_addr_en_i; ed = core_data_i; ede = core_data_en_i;
      es = core_strb_i; ese = core_strb_en_i;
    end
    vectors++;
    bad = 0;
    if (tdo_o !== m_sr[0]) begin
      bad = 1; $display("FAIL %s tdo got %b exp %b", tag, tdo_o, m_sr[0]);
    end
    if (pin_addr_o !== ea) begin
      bad = 1; $display("FAIL %s addr got %h exp %h", tag, pin_addr_o, ea);
    end
    if (pin_addr_en_o !== eae) begin
      bad = 1; $display("FAIL %s addr_en got %h exp %h", tag, pin_addr_en_o, eae);
    end
    if (pin_data_o !== ed) begin
      bad = 1; $display("FAIL %s data got %h exp %h", tag, pin_data_o, ed);
    end
    if (pin_data_en_o !== ede) begin
      bad = 1; $display("FAIL %s data_en got %h exp %h", tag, pin_data_en_o, ede);
    end
    if (pin_strb_o !== es) begin
      bad = 1; $display("FAIL %s strb got %b exp %b", tag, pin_strb_o, es);
    end
    if (pin_strb_en_o !== ese) begin
      bad = 1; $display("FAIL %s strb_en got %b exp %b", tag, pin_strb_en_o, ese);
    end
    if (bad) miscompares++;
  endtask

  // Drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(logic c, logic s, logic u, logic d, string tag);
    logic [LEN-1:0] old;
    old = m_sr;
    capture_i = c; shift_i = s; update_i = u; tdi_i = d;
    if (c) m_sr = cap_img();
    else if (s) m_sr = {d, m_sr[LEN-1:1]};
    if (u) m_lat = old;
    @(posedge clk_i);
    @(negedge clk_i);
    capture_i = 0; shift_i = 0; update_i = 0;
    check(tag);
  endtask

  task automatic randomize_core();
    core_addr_i = $urandom; core_addr_en_i = $urandom;
    core_data_i = $urandom; core_data_en_i = $urandom;
    core_strb_i = 3'($urandom); core_strb_en_i = 3'($urandom);
    pin_data_i = $urandom; pin_rst_i = 1'($urandom);
  endtask

  task automatic capture_and_drain();
    step(1, 0, 0, 0, cell_tag(0));
    for (int j = 1; j < LEN; j++) step(0, 1, 0, 0, cell_tag(j));
  endtask

  task automatic load_pattern(logic [LEN-1:0] pat, string tag);
    for (int j = 0; j < LEN; j++) step(0, 1, 0, pat[j], tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10");
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R10");
    extest_i = 1;
    step(0, 0, 0, 0, "R10");
    core_addr_en_i = '1; core_data_en_i = '1; core_strb_en_i = '1;
    step(0, 0, 0, 0, "R10");
    extest_i = 0;

    for (int i = 0; i < 4; i++) begin
      randomize_core();
      step(0, 0, 0, 0, "R9");
    end

    // Capture in sample mode with several patterns
    core_addr_i = 32'h8000_0001; core_addr_en_i = 32'h0F0F_0F0F;
    core_data_i = 32'hA5A5_5A5A; core_data_en_i = 32'hFFFF_0000;
    core_strb_i = 3'b101; core_strb_en_i = 3'b110;
    pin_data_i = 32'h1234_5678; pin_rst_i = 1;
    capture_and_drain();
    core_addr_i = '1; core_addr_en_i = '1; core_data_i = '1; core_data_en_i = '1;
    core_strb_i = '1; core_strb_en_i = '1; pin_data_i = '1; pin_rst_i = 1;
    capture_and_drain();
    randomize_core();
    capture_and_drain();

    // Chain length: one marker bit after a clear chain
    load_pattern('0, "R2");
    step(0, 1, 0, 1, "R1");
    for (int j = 0; j < LEN - 1; j++) step(0, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");

    // External test: shifting leaves the pins alone until update
    extest_i = 1;
    step(0, 0, 0, 0, "R6");
    for (int t = 0; t < 3; t++) begin
      logic [LEN-1:0] pat;
      for (int w = 0; w < LEN; w += 32) pat[w +: 32] = $urandom;
      if (t == 1) pat[197] = 0;
      load_pattern(pat, "R6");
      step(0, 0, 1, 0, "R7");
      randomize_core();
      step(0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, "R8");
      step(1, 0, 0, 0, "R6");
      step(0, 1, 0, 1, "R6");
    end
    load_pattern({LEN{1'b1}}, "R6");
    step(0, 0, 1, 0, "R8");
    load_pattern('0, "R6");
    step(0, 0, 1, 0, "R8");

    // Update while in sample mode, then switch to external test
    extest_i = 0;
    load_pattern({(LEN/2){2'b10}}, "R9");
    step(0, 0, 1, 0, "R9");
    extest_i = 1;
    step(0, 0, 0, 0, "R7");

    // Capture and shift together
    extest_i = 0;
    randomize_core();
    step(1, 1, 0, 1, "R11");
    step(0, 1, 0, 0, "R11");

    // Reset while loaded
    extest_i = 1;
    rst_ni = 0;
    m_sr = '0; m_lat = '0;
    @(negedge clk_i);
    check("R10");
    rst_ni = 1;
    step(0, 0, 0, 0, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule